// File: doc/BRIEF.md
# UART Ninth-Bit Generator and Checker

This block produces the optional extra bit that a serial transmitter appends after the data bits of a character, and checks that bit on the receive side. A 2-bit mode field and a 1-bit type field are decoded together. They select computed parity (even or odd), a parity bit forced to a fixed level, no extra bit at all, or multidrop addressing. In multidrop addressing the extra bit tells address characters apart from data characters instead of carrying parity.

The transmit side takes a character, a data-width selector and a valid strobe. One cycle later it presents the extra bit and a flag that says whether the serializer should send it. The receive side takes a received character, its received extra bit and a valid strobe. One cycle later it reports a parity error or the detection of an address character. Serialization and bit timing belong to the neighbouring shifter and are not part of this block.

Top module: `uart_ninth_bit`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, every output is 0.
- R2: tx_done is 1 in exactly the cycle after a cycle with tx_valid high, and 0 otherwise. tx_extra_bit and tx_send_extra for that character are valid while tx_done is 1.
- R3: With mode 00, the extra bit is parity over the lowest 5 + width_sel data bits. width_sel 0,1,2,3 selects 5,6,7,8 bits, and bits above that width have no effect. Type 0 makes the total count of ones even, and type 1 makes it odd. tx_send_extra is 1.
- R4: With mode 01 (forced parity), tx_extra_bit equals the type bit (0 gives low, 1 gives high) whatever the data, and tx_send_extra is 1.
- R5: With mode 10 (no parity), tx_send_extra is 0 and tx_extra_bit is 0 for either type value.
- R6: With mode 11 (multidrop), tx_extra_bit equals the type bit (0 marks data, 1 marks address), and tx_send_extra is 1.
- R7: rx_done is 1 in exactly the cycle after a cycle with rx_valid high, and 0 otherwise.
- R8: With mode 00, rx_parity_err is 1 when rx_extra_bit differs from the parity that R3 defines for rx_data, cfg_width_sel and cfg_type.
- R9: With mode 01, rx_parity_err is 1 when rx_extra_bit differs from the type bit.
- R10: With mode 11, rx_addr_det equals rx_extra_bit and rx_parity_err is 0, for either type value.
- R11: With mode 10, rx_parity_err and rx_addr_det are both 0 whatever the extra bit and the type.
- R12: rx_parity_err and rx_addr_det are 0 in every cycle where rx_done is 0. rx_addr_det is 0 in every mode other than 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Extra-bit mode: 00 computed, 01 forced, 10 none, 11 multidrop |
| cfg_type | input | 1 | Type bit, interpreted according to the mode |
| cfg_width_sel | input | 2 | Data width select, width = 5 + value |
| tx_valid | input | 1 | Transmit character strobe |
| tx_data | input | 8 | Transmit character |
| tx_done | output | 1 | Transmit result valid |
| tx_extra_bit | output | 1 | Extra bit to append |
| tx_send_extra | output | 1 | 1 when the extra bit is to be sent |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_extra_bit | input | 1 | Received extra bit |
| rx_done | output | 1 | Receive result valid |
| rx_parity_err | output | 1 | Extra bit did not match the expected parity |
| rx_addr_det | output | 1 | Multidrop address character received |

## Verification
The hardest case to reach is a character whose bits above the selected width are set and would change the parity if they were counted. Such a case exposes a mask that is one bit too wide or too narrow. The bench sweeps all 256 data values against every width, mode, type and received extra-bit value, so each of these cases is presented. It also drops the strobe between characters, which shows that the receive flags fall together with rx_done.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
   typedef enum logic [1:0] {
      XB_PARITY = 2'b00,
      XB_FORCE  = 2'b01,
      XB_NONE   = 2'b10,
      XB_MULTI  = 2'b11
   } xb_mode_e;
endpackage

// File: rtl/uart9_par_calc.sv
module uart9_par_calc #(
   parameter int MAX_W  = 8,
   parameter int MIN_W  = 5,
   localparam int SEL_W = (MAX_W - MIN_W + 1 > 1) ? $clog2(MAX_W - MIN_W + 1) : 1
) (
   input  logic [MAX_W-1:0] data,
   input  logic [SEL_W-1:0] width_sel,
   output logic             xor_out
);
   logic [MAX_W-1:0] keep;

   for (genvar i = 0; i < MAX_W; i++) begin : g_keep
      if (i < MIN_W) begin : g_fixed
         assign keep[i] = 1'b1;
      end else begin : g_sel
         assign keep[i] = (int'(width_sel) + MIN_W) > i;
      end
   end

   assign xor_out = ^(data & keep);
endmodule

// File: rtl/uart9_tx_gen.sv
module uart9_tx_gen
   import uart9_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic [1:0] mode,
   input  logic       typ,
   input  logic       par_raw,
   output logic       done,
   output logic       extra_bit,
   output logic       send
);
   xb_mode_e m;
   assign m = xb_mode_e'(mode);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         extra_bit <= 1'b0;
         send      <= 1'b0;
      end else begin
         done <= valid;
         if (valid) begin
            unique case (m)
               XB_PARITY: begin extra_bit <= par_raw ^ typ; send <= 1'b1; end
               XB_FORCE:  begin extra_bit <= typ;           send <= 1'b1; end
               XB_NONE:   begin extra_bit <= 1'b0;          send <= 1'b0; end
               XB_MULTI:  begin extra_bit <= typ;           send <= 1'b1; end
               default:   begin extra_bit <= 1'b0;          send <= 1'b0; end
            endcase
         end
      end
   end
endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk
   import uart9_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic [1:0] mode,
   input  logic       typ,
   input  logic       par_raw,
   input  logic       rx_bit,
   output logic       done,
   output logic       par_err,
   output logic       addr_det
);
   xb_mode_e m;
   logic     mismatch;

   assign m = xb_mode_e'(mode);

   always_comb begin
      unique case (m)
         XB_PARITY: mismatch = rx_bit != (par_raw ^ typ);
         XB_FORCE:  mismatch = rx_bit != typ;
         default:   mismatch = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         par_err  <= 1'b0;
         addr_det <= 1'b0;
      end else begin
         done     <= valid;
         par_err  <= valid && mismatch;
         addr_det <= valid && (m == XB_MULTI) && rx_bit;
      end
   end
endmodule

// File: rtl/uart_ninth_bit.sv
module uart_ninth_bit #(
   parameter int MAX_W  = 8,
   parameter int MIN_W  = 5,
   localparam int SEL_W = (MAX_W - MIN_W + 1 > 1) ? $clog2(MAX_W - MIN_W + 1) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_type,
   input  logic [SEL_W-1:0] cfg_width_sel,
   input  logic             tx_valid,
   input  logic [MAX_W-1:0] tx_data,
   output logic             tx_done,
   output logic             tx_extra_bit,
   output logic             tx_send_extra,
   input  logic             rx_valid,
   input  logic [MAX_W-1:0] rx_data,
   input  logic             rx_extra_bit,
   output logic             rx_done,
   output logic             rx_parity_err,
   output logic             rx_addr_det
);
   initial begin
      assert (MIN_W >= 1) else $error("MIN_W must be at least 1");
      assert (MAX_W >= MIN_W) else $error("MAX_W must not be below MIN_W");
   end

   logic tx_par, rx_par;

   uart9_par_calc #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_tx_par (
      .data(tx_data), .width_sel(cfg_width_sel), .xor_out(tx_par));

   uart9_par_calc #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_rx_par (
      .data(rx_data), .width_sel(cfg_width_sel), .xor_out(rx_par));

   uart9_tx_gen u_tx (
      .clk(clk), .rst_n(rst_n), .valid(tx_valid), .mode(cfg_mode),
      .typ(cfg_type), .par_raw(tx_par), .done(tx_done),
      .extra_bit(tx_extra_bit), .send(tx_send_extra));

   uart9_rx_chk u_rx (
      .clk(clk), .rst_n(rst_n), .valid(rx_valid), .mode(cfg_mode),
      .typ(cfg_type), .par_raw(rx_par), .rx_bit(rx_extra_bit),
      .done(rx_done), .par_err(rx_parity_err), .addr_det(rx_addr_det));
endmodule

// File: rtl/uart9_checker.sv
module uart9_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic       cfg_type,
   input logic       tx_valid,
   input logic       tx_done,
   input logic       tx_extra_bit,
   input logic       tx_send_extra,
   input logic       rx_valid,
   input logic       rx_extra_bit,
   input logic       rx_done,
   input logic       rx_parity_err,
   input logic       rx_addr_det
);
   p_tx_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> tx_done);
   p_tx_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |=> !tx_done);
   p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && cfg_mode == 2'b01) |=> (tx_extra_bit == $past(cfg_type)) && tx_send_extra);
   p_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && cfg_mode == 2'b10) |=> !tx_send_extra && !tx_extra_bit);
   p_multi_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && cfg_mode == 2'b11) |=> (tx_extra_bit == $past(cfg_type)) && tx_send_extra);
   p_rx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> rx_done);
   p_force_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_mode == 2'b01) |=> (rx_parity_err == ($past(rx_extra_bit) != $past(cfg_type))));
   p_multi_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_mode == 2'b11) |=> !rx_parity_err && (rx_addr_det == $past(rx_extra_bit)));
   p_none_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_mode == 2'b10) |=> !rx_parity_err && !rx_addr_det);
   p_flags_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_parity_err || rx_addr_det) |-> rx_done);
endmodule

bind uart_ninth_bit uart9_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_type(cfg_type),
   .tx_valid(tx_valid), .tx_done(tx_done), .tx_extra_bit(tx_extra_bit),
   .tx_send_extra(tx_send_extra), .rx_valid(rx_valid),
   .rx_extra_bit(rx_extra_bit), .rx_done(rx_done),
   .rx_parity_err(rx_parity_err), .rx_addr_det(rx_addr_det));

// File: tb/sim_uart_ninth_bit.sv
`timescale 1ns/1ps
module sim_uart_ninth_bit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic       cfg_type = 1'b0;
   logic [1:0] cfg_width_sel = 2'b00;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_extra_bit = 1'b0;
   logic       tx_done, tx_extra_bit, tx_send_extra;
   logic       rx_done, rx_parity_err, rx_addr_det;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   uart_ninth_bit u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_type(cfg_type),
      .cfg_width_sel(cfg_width_sel), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_done(tx_done), .tx_extra_bit(tx_extra_bit), .tx_send_extra(tx_send_extra),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_extra_bit(rx_extra_bit),
      .rx_done(rx_done), .rx_parity_err(rx_parity_err), .rx_addr_det(rx_addr_det));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b mode=%0b type=%0b wsel=%0d tx=%02h rx=%02h rxbit=%0b",
                  tag, act, exp, cfg_mode, cfg_type, cfg_width_sel, tx_data, rx_data, rx_extra_bit);
      end
   endtask

   function automatic logic ones_odd(input logic [7:0] d, input int w);
      int n = 0;
      for (int k = 0; k < w; k++) if (d[k]) n++;
      return logic'(n % 2);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic par, exp_tx_bit, exp_send, exp_err, exp_addr;
      // R1: outputs held at 0 during reset
      repeat (3) @(negedge clk);
      chk("R1 tx_done", tx_done, 1'b0);
      chk("R1 tx_extra_bit", tx_extra_bit, 1'b0);
      chk("R1 tx_send_extra", tx_send_extra, 1'b0);
      chk("R1 rx_done", rx_done, 1'b0);
      chk("R1 rx_parity_err", rx_parity_err, 1'b0);
      chk("R1 rx_addr_det", rx_addr_det, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tx_done after reset", tx_done, 1'b0);
      chk("R1 rx_done after reset", rx_done, 1'b0);

      for (int md = 0; md < 4; md++)
         for (int ty = 0; ty < 2; ty++)
            for (int ws = 0; ws < 4; ws++)
               for (int eb = 0; eb < 2; eb++)
                  for (int d = 0; d < 256; d++) begin
                     cfg_mode      = 2'(md);
                     cfg_type      = 1'(ty);
                     cfg_width_sel = 2'(ws);
                     tx_data       = 8'(d);
                     rx_data       = 8'(d ^ 8'hA5);
                     rx_extra_bit  = 1'(eb);
                     tx_valid      = 1'b1;
                     rx_valid      = 1'b1;
                     @(negedge clk);
                     // expected transmit result
                     par = ones_odd(tx_data, 5 + ws) ^ cfg_type;
                     case (md)
                        0: begin exp_tx_bit = par;      exp_send = 1'b1; end
                        1: begin exp_tx_bit = cfg_type; exp_send = 1'b1; end
                        2: begin exp_tx_bit = 1'b0;     exp_send = 1'b0; end
                        default: begin exp_tx_bit = cfg_type; exp_send = 1'b1; end
                     endcase
                     chk("R2 tx_done", tx_done, 1'b1);
                     case (md)
                        0: chk("R3 parity bit", tx_extra_bit, exp_tx_bit);
                        1: chk("R4 forced bit", tx_extra_bit, exp_tx_bit);
                        2: chk("R5 no-parity bit", tx_extra_bit, exp_tx_bit);
                        default: chk("R6 multidrop bit", tx_extra_bit, exp_tx_bit);
                     endcase
                     if (md == 2) chk("R5 send flag", tx_send_extra, exp_send);
                     else chk("R3 R4 R6 send flag", tx_send_extra, exp_send);
                     // expected receive result
                     par = ones_odd(rx_data, 5 + ws) ^ cfg_type;
                     case (md)
                        0: begin exp_err = (rx_extra_bit != par);      exp_addr = 1'b0; end
                        1: begin exp_err = (rx_extra_bit != cfg_type); exp_addr = 1'b0; end
                        2: begin exp_err = 1'b0;                      exp_addr = 1'b0; end
                        default: begin exp_err = 1'b0;                exp_addr = rx_extra_bit; end
                     endcase
                     chk("R7 rx_done", rx_done, 1'b1);
                     case (md)
                        0: chk("R8 parity error", rx_parity_err, exp_err);
                        1: chk("R9 forced error", rx_parity_err, exp_err);
                        2: chk("R11 no-parity error", rx_parity_err, exp_err);
                        default: chk("R10 multidrop error", rx_parity_err, exp_err);
                     endcase
                     if (md == 3) chk("R10 address detect", rx_addr_det, exp_addr);
                     else if (md == 2) chk("R11 address detect", rx_addr_det, exp_addr);
                     else chk("R12 address detect outside multidrop", rx_addr_det, exp_addr);
                     tx_valid = 1'b0;
                     rx_valid = 1'b0;
                     @(negedge clk);
                     chk("R2 tx_done drops", tx_done, 1'b0);
                     chk("R7 rx_done drops", rx_done, 1'b0);
                     chk("R12 parity error idle", rx_parity_err, 1'b0);
                     chk("R12 address idle", rx_addr_det, 1'b0);
                  end

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule